// File: doc/BRIEF.md
# Clock Ratio Divider and Output Gating

This block produces the clock lines that fan out of a system clock generator. A fast core clock drives two internal sources. One is a host-rate source at half the core rate. The other is a PCI-rate source that divides the core clock by an integer ratio chosen through a 3-bit code. Every output line passes through its own gate, and a configuration enable bit controls each gate. A gate starts or stops its line only while the source is low, so a line never shows a shortened high pulse.

An active-low power-down input halts every gated line at logic 0. The one exception is the free-running host line, which keeps toggling. A tristate request drives a single output-enable that the pads use to release all lines to high impedance. The memory fan-out lines are switched in groups of four, one enable bit per group, and a single extra memory line has a bit of its own. All control pins are plain levels. The block has no data stream and no handshake.

Top module: `clk_fanout_gate`

## Requirements
- R1: The ratio code selects the divide value of the PCI lines as code + 2 for codes 0 to 4, which gives periods of 2, 3, 4, 5 and 6 core cycles.
- R2: Ratio codes 5, 6 and 7 are undefined and divide by 6, the slowest defined ratio.
- R3: Each PCI period is high for floor(N/2) core cycles and low for the rest. This gives 1/1, 1/2, 2/2, 2/3 and 3/3 for N = 2 to 6.
- R4: A new ratio code takes effect only when the current divided period ends. The period in progress completes at its old length.
- R5: The host lines and all memory lines, when enabled, toggle every core cycle: period 2, high 1.
- R6: A PCI line whose enable bit (bit i controls pci_clk[i]) is 0 stops and rests at 0. With the bit at 1 the line runs.
- R7: sdram_grp_en[g] enables sdram_clk[4g+3:4g], and sdram_solo_en enables sdram_solo_clk. A line runs exactly when its bit is 1.
- R8: Every high pulse on a gated line has its full length. Changes of an enable bit or of power-down never shorten a pulse.
- R9: With pwrdn_n low, every line except host_free_clk halts at 0, and host_free_clk keeps its period of 2. When pwrdn_n returns high, the lines run again.
- R10: clk_oe follows the inverse of tristate_req two core clock edges later.
- R11: During reset all clock outputs are 0 and clk_oe is 1.
- R12: After reset the first PCI period uses the ratio code present at the first edge. The PCI lines rise on the second edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_core | input | 1 | Fast core clock |
| rst_n | input | 1 | Active-low reset |
| pwrdn_n | input | 1 | Active-low power-down, asynchronous |
| tristate_req | input | 1 | 1 requests high impedance on all lines, asynchronous |
| ratio_sel | input | 3 | PCI divide ratio code |
| pci_en | input | NUM_PCI | Per-line PCI enables |
| sdram_grp_en | input | SDR_GRPS | One enable per group of four memory lines |
| sdram_solo_en | input | 1 | Enable of the single extra memory line |
| host_free_en | input | 1 | Enable of the free-running host line |
| host_gated_en | input | 1 | Enable of the gated host line |
| pci_clk | output | NUM_PCI | PCI-rate clock lines |
| sdram_clk | output | SDR_GRPS*SDR_PER_GRP | Grouped memory clock lines |
| sdram_solo_clk | output | 1 | Single extra memory clock line |
| host_free_clk | output | 1 | Host line, exempt from power-down |
| host_gated_clk | output | 1 | Host line, halted by power-down |
| clk_oe | output | 1 | Pad output enable, 0 means high impedance |

## Verification
Every clock line sits two registers behind the ratio counter or the half-rate toggle. After reset the PCI lines therefore rise on the second edge. A ratio code change shows up in the rise-to-rise interval after the one in progress. clk_oe changes two edges after tristate_req. Enable and power-down changes pass through the run flop at the next low phase of the source. The power-down path adds two synchroniser stages in front of that.

The bench samples outputs at falling edges. For one-shot events it checks the exact edge. For steady-state behaviour it lets two full periods settle first, then counts rises and measures high and rise-to-rise lengths over a window. Only pulses that both start and end inside the window are counted.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
  localparam int RATIO_W   = 3;
  localparam int CNT_W     = 3;
  localparam int DIV_MIN   = 2;
  localparam int DIV_MAX   = 6;
  localparam int NUM_CODES = DIV_MAX - DIV_MIN + 1;

  // Map a ratio code to its divide value; undefined codes fall back to the slowest ratio.
  function automatic logic [CNT_W-1:0] ratio_decode(input logic [RATIO_W-1:0] code);
    if (int'(code) < NUM_CODES)
      return CNT_W'(code) + CNT_W'(DIV_MIN);
    else
      return CNT_W'(DIV_MAX);
  endfunction
endpackage

// File: rtl/clk_sync2.sv
module clk_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/clk_ratio_div.sv
module clk_ratio_div
  import clkgate_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratio_sel,
  output logic               div_clk
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] div_q, div_n;
  logic [CNT_W-1:0] hi_len;
  logic             wrap;

  always_comb begin
    wrap = (cnt_q == div_q - CNT_W'(1));
    if (wrap) begin
      cnt_n = '0;
      div_n = ratio_decode(ratio_sel);
    end else begin
      cnt_n = cnt_q + CNT_W'(1);
      div_n = div_q;
    end
    hi_len = div_n >> 1;
  end

  // Reset parks the counter on its last count so the first edge opens a fresh period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= CNT_W'(DIV_MAX - 1);
      div_q   <= CNT_W'(DIV_MAX);
      div_clk <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      div_q   <= div_n;
      div_clk <= (cnt_n < hi_len);
    end
  end
endmodule

// File: rtl/clk_gate_lane.sv
module clk_gate_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic base,
  input  logic en,
  output logic gclk
);
  logic run_q;

  // The run decision is refreshed only while the source is low, so a high phase is all or nothing.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      gclk  <= 1'b0;
    end else begin
      if (!base) run_q <= en;
      gclk <= base & run_q;
    end
  end
endmodule

// File: rtl/clk_gate_bank.sv
module clk_gate_bank #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base,
  input  logic [LANES-1:0] en,
  output logic [LANES-1:0] gclk
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    clk_gate_lane u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .base  (base),
      .en    (en[i]),
      .gclk  (gclk[i])
    );
  end
endmodule

// File: rtl/clk_fanout_gate.sv
module clk_fanout_gate
  import clkgate_pkg::*;
#(
  parameter int NUM_PCI     = 6,
  parameter int SDR_GRPS    = 3,
  parameter int SDR_PER_GRP = 4
) (
  input  logic                            clk_core,
  input  logic                            rst_n,
  input  logic                            pwrdn_n,
  input  logic                            tristate_req,
  input  logic [RATIO_W-1:0]              ratio_sel,
  input  logic [NUM_PCI-1:0]              pci_en,
  input  logic [SDR_GRPS-1:0]             sdram_grp_en,
  input  logic                            sdram_solo_en,
  input  logic                            host_free_en,
  input  logic                            host_gated_en,
  output logic [NUM_PCI-1:0]              pci_clk,
  output logic [SDR_GRPS*SDR_PER_GRP-1:0] sdram_clk,
  output logic                            sdram_solo_clk,
  output logic                            host_free_clk,
  output logic                            host_gated_clk,
  output logic                            clk_oe
);
  localparam int NUM_SDR   = SDR_GRPS * SDR_PER_GRP;
  localparam int SDR_LANES = NUM_SDR + 1;

  logic                 pd_run;
  logic                 tri_s;
  logic                 pci_base;
  logic                 host_base;
  logic [NUM_SDR-1:0]   sdr_en_x;
  logic [SDR_LANES-1:0] sdr_lane_en;
  logic [SDR_LANES-1:0] sdr_lane_clk;
  logic [1:0]           host_lane_en;
  logic [1:0]           host_lane_clk;

  clk_sync2 #(.RST_VAL(1'b1)) u_pd_sync (
    .clk(clk_core), .rst_n(rst_n), .d(pwrdn_n), .q(pd_run)
  );

  clk_sync2 #(.RST_VAL(1'b0)) u_tri_sync (
    .clk(clk_core), .rst_n(rst_n), .d(tristate_req), .q(tri_s)
  );

  clk_ratio_div u_pci_div (
    .clk(clk_core), .rst_n(rst_n), .ratio_sel(ratio_sel), .div_clk(pci_base)
  );

  always_ff @(posedge clk_core or negedge rst_n) begin
    if (!rst_n) host_base <= 1'b0;
    else        host_base <= ~host_base;
  end

  for (genvar g = 0; g < SDR_GRPS; g++) begin : g_grp
    assign sdr_en_x[g*SDR_PER_GRP +: SDR_PER_GRP] = {SDR_PER_GRP{sdram_grp_en[g] & pd_run}};
  end

  assign sdr_lane_en  = {sdram_solo_en & pd_run, sdr_en_x};
  assign host_lane_en = {host_free_en, host_gated_en & pd_run};

  clk_gate_bank #(.LANES(NUM_PCI)) u_pci_bank (
    .clk(clk_core), .rst_n(rst_n), .base(pci_base),
    .en(pci_en & {NUM_PCI{pd_run}}), .gclk(pci_clk)
  );

  clk_gate_bank #(.LANES(SDR_LANES)) u_sdr_bank (
    .clk(clk_core), .rst_n(rst_n), .base(host_base),
    .en(sdr_lane_en), .gclk(sdr_lane_clk)
  );

  clk_gate_bank #(.LANES(2)) u_host_bank (
    .clk(clk_core), .rst_n(rst_n), .base(host_base),
    .en(host_lane_en), .gclk(host_lane_clk)
  );

  assign sdram_clk      = sdr_lane_clk[NUM_SDR-1:0];
  assign sdram_solo_clk = sdr_lane_clk[NUM_SDR];
  assign host_gated_clk = host_lane_clk[0];
  assign host_free_clk  = host_lane_clk[1];
  assign clk_oe         = ~tri_s;
endmodule

// File: rtl/clk_fanout_gate_chk.sv
module clk_fanout_gate_chk #(
  parameter int NUM_PCI = 6,
  parameter int NUM_SDR = 12
) (
  input logic               clk_core,
  input logic               rst_n,
  input logic               pwrdn_n,
  input logic               tristate_req,
  input logic [NUM_PCI-1:0] pci_en,
  input logic [NUM_PCI-1:0] pci_clk,
  input logic [NUM_SDR-1:0] sdram_clk,
  input logic               sdram_solo_clk,
  input logic               host_free_clk,
  input logic               host_gated_clk,
  input logic               clk_oe
);
  logic [3:0] age;
  logic [4:0] pd_low;
  logic [4:0] off_cnt;
  logic [2:0] hi_cnt;

  always_ff @(posedge clk_core or negedge rst_n) begin
    if (!rst_n) begin
      age     <= '0;
      pd_low  <= '0;
      off_cnt <= '0;
      hi_cnt  <= '0;
    end else begin
      if (age != 4'hF) age <= age + 4'd1;
      if (pwrdn_n) pd_low <= '0;
      else if (pd_low != 5'h1F) pd_low <= pd_low + 5'd1;
      if (pci_en[0]) off_cnt <= '0;
      else if (off_cnt != 5'h1F) off_cnt <= off_cnt + 5'd1;
      if (!pci_clk[0]) hi_cnt <= '0;
      else if (hi_cnt != 3'h7) hi_cnt <= hi_cnt + 3'd1;
    end
  end

  assert_oe_follow_R10: assert property (@(posedge clk_core) disable iff (!rst_n)
    (age >= 4'd3) |-> (clk_oe == !$past(tristate_req, 2)));

  assert_pd_halt_R9: assert property (@(posedge clk_core) disable iff (!rst_n)
    (pd_low >= 5'd12) |-> (pci_clk == '0 && sdram_clk == '0 && !sdram_solo_clk && !host_gated_clk));

  assert_host_single_high_R5: assert property (@(posedge clk_core) disable iff (!rst_n)
    $past(host_free_clk) |-> !host_free_clk);

  assert_pci_pulse_max_R3: assert property (@(posedge clk_core) disable iff (!rst_n)
    hi_cnt <= 3'd3);

  assert_stop_low_R6: assert property (@(posedge clk_core) disable iff (!rst_n)
    (off_cnt >= 5'd10) |-> !pci_clk[0]);
endmodule

bind clk_fanout_gate clk_fanout_gate_chk #(.NUM_PCI(NUM_PCI), .NUM_SDR(NUM_SDR)) u_chk (.*);

// File: tb/clk_fanout_gate_test.sv
`timescale 1ns/1ps
module clk_fanout_gate_test;
  logic        clk_core = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwrdn_n = 1'b1;
  logic        tristate_req = 1'b0;
  logic [2:0]  ratio_sel = 3'd2;
  logic [5:0]  pci_en = '1;
  logic [2:0]  sdram_grp_en = '1;
  logic        sdram_solo_en = 1'b1;
  logic        host_free_en = 1'b1;
  logic        host_gated_en = 1'b1;
  logic [5:0]  pci_clk;
  logic [11:0] sdram_clk;
  logic        sdram_solo_clk, host_free_clk, host_gated_clk, clk_oe;

  int nrun = 0;
  int nfail = 0;
  bit done = 0;
  int m_rises, m_hmin, m_hmax, m_pmin, m_pmax;
  bit m_any;

  // Index map: pci 0..5, sdram 6..17, solo 18, host gated 19, host free 20.
  logic [20:0] allv;
  assign allv = {host_free_clk, host_gated_clk, sdram_solo_clk, sdram_clk, pci_clk};

  always #2.5 clk_core = ~clk_core;

  clk_fanout_gate uut (
    .clk_core(clk_core), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .tristate_req(tristate_req),
    .ratio_sel(ratio_sel), .pci_en(pci_en), .sdram_grp_en(sdram_grp_en),
    .sdram_solo_en(sdram_solo_en), .host_free_en(host_free_en), .host_gated_en(host_gated_en),
    .pci_clk(pci_clk), .sdram_clk(sdram_clk), .sdram_solo_clk(sdram_solo_clk),
    .host_free_clk(host_free_clk), .host_gated_clk(host_gated_clk), .clk_oe(clk_oe)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nrun++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk_core);
  endtask

  task automatic measure(input int idx, input int ncyc);
    logic prev, v;
    int hl, last;
    bit inp, seen;
    m_rises = 0; m_hmin = 999; m_hmax = 0; m_pmin = 999; m_pmax = 0; m_any = 0;
    hl = 0; last = 0; inp = 0; seen = 0;
    @(negedge clk_core);
    prev = allv[idx];
    if (prev) m_any = 1;
    for (int c = 1; c < ncyc; c++) begin
      @(negedge clk_core);
      v = allv[idx];
      if (v) m_any = 1;
      if (v && !prev) begin
        m_rises++;
        if (seen) begin
          if (c - last < m_pmin) m_pmin = c - last;
          if (c - last > m_pmax) m_pmax = c - last;
        end
        seen = 1; last = c; inp = 1; hl = 1;
      end else if (v && inp) begin
        hl++;
      end else if (!v && prev && inp) begin
        if (hl < m_hmin) m_hmin = hl;
        if (hl > m_hmax) m_hmax = hl;
        inp = 0;
      end
      prev = v;
    end
  endtask

  task automatic count_to_rise(output int n);
    logic prev;
    n = 0;
    prev = allv[0];
    for (int c = 0; c < 40; c++) begin
      @(negedge clk_core);
      n++;
      if (allv[0] && !prev) return;
      prev = allv[0];
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_core);
    if (!done) begin
      nrun++; nfail++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", nrun, nfail);
      $finish;
    end
  end

  initial begin
    int n, expd;
    // R11: reset state
    waitn(3);
    chk(allv == '0, "R11", "outputs in reset", int'(allv), 0);
    chk(clk_oe == 1'b1, "R11", "oe in reset", clk_oe, 1);
    rst_n = 1'b1;
    // R12: first period uses code 2 (divide 4), rise on second edge
    @(negedge clk_core);
    chk(pci_clk[0] == 1'b0, "R12", "pci after edge 1", pci_clk[0], 0);
    @(negedge clk_core);
    chk(pci_clk[0] == 1'b1, "R12", "pci after edge 2", pci_clk[0], 1);
    measure(0, 20);
    chk(m_pmin == 4 && m_pmax == 4, "R12", "first periods", m_pmax, 4);

    // R1 R2 R3: sweep all ratio codes
    for (int s = 0; s < 8; s++) begin
      ratio_sel = 3'(s);
      waitn(16);
      expd = (s < 5) ? s + 2 : 6;
      measure(0, 48);
      chk(m_rises > 0 && m_pmin == expd && m_pmax == expd, (s < 5) ? "R1" : "R2", "pci period", m_pmax, expd);
      chk(m_hmin == expd / 2 && m_hmax == expd / 2, "R3", "pci high length", m_hmax, expd / 2);
    end
    ratio_sel = 3'd4;
    waitn(16);
    for (int i = 0; i < 6; i++) begin
      measure(i, 30);
      chk(m_pmin == 6 && m_pmax == 6, "R1", "pci line period at divide 6", m_pmax, 6);
    end

    // R5: host and memory lines at half core rate
    for (int i = 6; i < 21; i++) begin
      measure(i, 20);
      chk(m_rises > 0 && m_pmin == 2 && m_pmax == 2 && m_hmax == 1, "R5", "half rate line", m_pmax, 2);
    end

    // R6: walking-zero PCI enables
    ratio_sel = 3'd1;
    for (int z = 0; z < 6; z++) begin
      pci_en = ~(6'd1 << z);
      waitn(16);
      for (int i = 0; i < 6; i++) begin
        measure(i, 24);
        if (i == z) chk(!m_any, "R6", "stopped pci line level", m_any, 0);
        else        chk(m_rises > 0, "R6", "running pci line", m_rises, 1);
      end
    end
    pci_en = '1;

    // R7: memory group and solo enables, all patterns
    for (int p = 0; p < 16; p++) begin
      {sdram_solo_en, sdram_grp_en} = 4'(p);
      waitn(8);
      for (int j = 0; j < 13; j++) begin
        bit on;
        on = (j == 12) ? p[3] : p[j / 4];
        measure(6 + j, 12);
        chk((m_rises > 0) == on && (on || !m_any), "R7", "memory line run state", m_rises, on ? 5 : 0);
      end
    end
    sdram_grp_en = '1; sdram_solo_en = 1'b1;

    // R8: toggling enables never shorten a pulse
    for (int s = 1; s < 5; s += 3) begin
      ratio_sel = 3'(s);
      waitn(16);
      fork
        measure(0, 120);
        for (int k = 0; k < 16; k++) begin
          waitn(7);
          pci_en[0] = ~pci_en[0];
        end
      join
      pci_en[0] = 1'b1;
      chk(m_rises > 0 && m_hmin == (s + 2) / 2 && m_hmax == (s + 2) / 2, "R8", "pci pulse under toggling", m_hmin, (s + 2) / 2);
    end
    fork
      measure(6, 60);
      for (int k = 0; k < 18; k++) begin
        waitn(3);
        sdram_grp_en[0] = ~sdram_grp_en[0];
      end
    join
    sdram_grp_en[0] = 1'b1;
    chk(m_rises > 0 && m_hmin == 1 && m_hmax == 1, "R8", "memory pulse under toggling", m_hmin, 1);

    // R4: ratio change mid-period finishes the old period
    ratio_sel = 3'd4;
    waitn(16);
    count_to_rise(n);
    @(negedge clk_core);
    ratio_sel = 3'd0;
    count_to_rise(n);
    chk(n + 1 == 6, "R4", "period in progress", n + 1, 6);
    count_to_rise(n);
    chk(n == 2, "R4", "next period", n, 2);

    // R8 R9: power-down at every phase of a divide-6 period
    ratio_sel = 3'd4;
    for (int off = 0; off < 6; off++) begin
      pwrdn_n = 1'b1;
      waitn(14);
      fork
        measure(0, 30);
        begin waitn(6 + off); pwrdn_n = 1'b0; end
      join
      chk(m_rises == 0 || (m_hmin == 3 && m_hmax == 3), "R8", "pulse across power-down", m_hmin, 3);
    end
    waitn(10);
    for (int i = 0; i < 20; i++) begin
      measure(i, 10);
      chk(!m_any, "R9", "halted line", m_any, 0);
    end
    measure(20, 20);
    chk(m_rises > 0 && m_pmin == 2 && m_pmax == 2, "R9", "free host line keeps running", m_pmax, 2);
    pwrdn_n = 1'b1;
    waitn(16);
    measure(0, 30);
    chk(m_rises > 0 && m_pmax == 6, "R9", "pci resumes", m_pmax, 6);

    // R10: tristate output enable two edges late
    tristate_req = 1'b1;
    @(negedge clk_core);
    chk(clk_oe == 1'b1, "R10", "oe after edge 1", clk_oe, 1);
    @(negedge clk_core);
    chk(clk_oe == 1'b0, "R10", "oe after edge 2", clk_oe, 0);
    tristate_req = 1'b0;
    @(negedge clk_core);
    chk(clk_oe == 1'b0, "R10", "oe release edge 1", clk_oe, 0);
    @(negedge clk_core);
    chk(clk_oe == 1'b1, "R10", "oe release edge 2", clk_oe, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end
endmodule